// File: doc/BRIEF.md
# Max-Log State Metric Step Unit

This block advances a trellis state-metric vector by one step, in either the forward or the backward direction, for a small trellis with 2^SB states. It targets a soft-output trellis decoder. The caller presents the current metric vector and the branch metric of every transition. For each new state, the block forms both candidate sums, saturates them, and keeps the larger one. It applies no correction term.

Fixed-point values would otherwise creep upward step after step until they pin at the top of the range. To prevent this, the block can rebase the new vector so that its best state reads zero. The rebase subtracts the vector maximum from every entry. It runs as a three-stage tail after the compare. A runtime interval sets how often the rebase is applied: on every step, or only on every k-th accepted step, counted from reset. A step that skips the rebase finishes three cycles sooner.

The trellis is shift-register shaped. A transition from state p with input bit b leads to state ((p<<1)|b) mod 2^SB.

Top module: `ml_metric_step`

## Requirements
- R1: After reset, out_valid is low, and the internal step count is zero. So with interval k ≥ 2, the k-th accepted step after reset is the first one normalized.
- R2: Forward (dir = 0) connectivity. new[s] = max over b of sat(m[p] + g[2p + (s&1)]), where p = (s>>1) | (b<<(SB-1)). State s sits at metric bits [s*MW +: MW]. Branch index 2*from + bit sits at branch bits [idx*MW +: MW].
- R3: Backward (dir = 1) connectivity. new[s] = max over b of sat(m[(2s+b) mod S] + g[2s+b]), with the same packing as R2.
- R4: Every metric-plus-branch sum saturates to the MW-bit signed range (−256..255 for MW = 9). It never wraps.
- R5: Combining is a plain maximum with no correction term. Two equal candidates give exactly that value.
- R6: On a step that is not normalized, out_valid pulses for one cycle, two clock edges after in_valid is sampled, with the new vector on metric_out.
- R7: On a normalized step, out_valid pulses five clock edges after in_valid is sampled.
- R8: A normalized output equals each compared value minus the vector maximum, saturated at the negative limit. Every entry is ≤ 0 and at least one entry is 0.
- R9: norm_interval is sampled with in_valid. A value of 0 or 1 normalizes every step. A value k ≥ 2 normalizes every k-th accepted step.
- R10: Input spacing. After a step that is not normalized, in_valid may return no sooner than 2 cycles later. After a normalized step, the wait is at least 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Starts one step with the inputs below |
| dir | input | 1 | 0 forward, 1 backward connectivity |
| norm_interval | input | CW | Normalize every k-th step (0 or 1: every step) |
| metric_in | input | S*MW | Current metric vector, signed 7.2 per state |
| branch_in | input | 2*S*MW | Branch metrics indexed 2*from + bit |
| out_valid | output | 1 | New vector present on metric_out |
| metric_out | output | S*MW | New metric vector |

## Verification
The assertions assume that the caller respects the R10 spacing. The pipeline stages hold no backpressure, so closer inputs would overwrite a step that is still in flight. The stimulus therefore always waits exactly 2 or 4 cycles, based on its own prediction of whether a step normalizes. The stimulus covers the tightest legal spacing in both cases. Metric and branch values are drawn across the full signed 9-bit range, including both limits, so that saturation is reached in the sums and in the rebase subtraction.

// File: rtl/ml_pkg.sv
package ml_pkg;
  typedef enum logic {DIR_FWD = 1'b0, DIR_BWD = 1'b1} dir_e;
endpackage

// File: rtl/ml_step_ctrl.sv
module ml_step_ctrl #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] norm_interval,
  output logic          norm_now,
  output logic          a_vld,
  output logic          a_norm,
  output logic          b_vld,
  output logic          c_vld,
  output logic          d_vld
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          a_vld_d, a_norm_d, b_vld_d, c_vld_d, d_vld_d;

  // R9: decide whether the step presented now is normalized
  always_comb begin
    norm_now = (norm_interval <= CW'(1)) || (cnt_q == norm_interval - CW'(1));
    cnt_d    = cnt_q;
    if (in_valid) cnt_d = norm_now ? '0 : cnt_q + CW'(1);
    a_vld_d  = in_valid;
    a_norm_d = in_valid & norm_now;
    b_vld_d  = a_vld & a_norm;
    c_vld_d  = b_vld;
    d_vld_d  = c_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      a_vld  <= 1'b0;
      a_norm <= 1'b0;
      b_vld  <= 1'b0;
      c_vld  <= 1'b0;
      d_vld  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      a_vld  <= a_vld_d;
      a_norm <= a_norm_d;
      b_vld  <= b_vld_d;
      c_vld  <= c_vld_d;
      d_vld  <= d_vld_d;
    end
  end
endmodule

// File: rtl/ml_acs_unit.sv
module ml_acs_unit #(
  parameter int SB = 2,
  parameter int MW = 9
) (
  input  logic                clk,
  input  logic                load_en,
  input  logic                dir,
  input  logic [(1<<SB)*MW-1:0]   metric_in,
  input  logic [2*(1<<SB)*MW-1:0] branch_in,
  output logic [(1<<SB)*MW-1:0]   acs_max
);
  import ml_pkg::*;
  localparam int S = 1 << SB;
  localparam logic signed [MW-1:0] VMAX = {1'b0, {(MW-1){1'b1}}};
  localparam logic signed [MW-1:0] VMIN = {1'b1, {(MW-1){1'b0}}};

  function automatic logic signed [MW-1:0] sat_add(input logic signed [MW-1:0] x,
                                                   input logic signed [MW-1:0] y);
    logic signed [MW:0] t;
    t = {x[MW-1], x} + {y[MW-1], y};
    if (t[MW] != t[MW-1]) sat_add = t[MW] ? VMIN : VMAX;
    else                  sat_add = t[MW-1:0];
  endfunction

  logic signed [MW-1:0] sum_q [S][2];

  for (genvar s = 0; s < S; s++) begin : g_st
    for (genvar b = 0; b < 2; b++) begin : g_br
      localparam int FSRC = (s >> 1) | (b << (SB - 1));
      localparam int FBR  = 2 * FSRC + (s & 1);
      localparam int BSRC = ((s << 1) | b) & (S - 1);
      localparam int BBR  = 2 * s + b;
      logic signed [MW-1:0] pm, bm, sd;
      // R2 / R3: connectivity chosen by direction
      always_comb begin
        if (dir_e'(dir) == DIR_BWD) begin
          pm = metric_in[BSRC*MW +: MW];
          bm = branch_in[BBR*MW +: MW];
        end else begin
          pm = metric_in[FSRC*MW +: MW];
          bm = branch_in[FBR*MW +: MW];
        end
        sd = sat_add(pm, bm);
      end
      always_ff @(posedge clk) begin
        if (load_en) sum_q[s][b] <= sd;
      end
    end
    // R5: plain maximum, no correction
    always_comb begin
      acs_max[s*MW +: MW] = (sum_q[s][1] > sum_q[s][0]) ? sum_q[s][1] : sum_q[s][0];
    end
  end
endmodule

// File: rtl/ml_norm_pipe.sv
module ml_norm_pipe #(
  parameter int SB = 2,
  parameter int MW = 9
) (
  input  logic                  clk,
  input  logic                  ld_acs,
  input  logic                  ld_half,
  input  logic                  ld_max,
  input  logic [(1<<SB)*MW-1:0] acs_in,
  output logic [(1<<SB)*MW-1:0] norm_out
);
  localparam int S = 1 << SB;
  localparam int H = S / 2;
  localparam logic signed [MW-1:0] VMIN = {1'b1, {(MW-1){1'b0}}};

  logic signed [MW-1:0] acs_q [S];
  logic signed [MW-1:0] half_q [H];
  logic signed [MW-1:0] max_q, max_d;

  // stage 1: capture compared vector
  for (genvar s = 0; s < S; s++) begin : g_cap
    always_ff @(posedge clk) begin
      if (ld_acs) acs_q[s] <= acs_in[s*MW +: MW];
    end
  end

  // stage 2: pairwise reduction
  for (genvar h = 0; h < H; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (ld_half) half_q[h] <= (acs_q[2*h+1] > acs_q[2*h]) ? acs_q[2*h+1] : acs_q[2*h];
    end
  end

  // stage 3: final reduction
  always_comb begin
    max_d = half_q[0];
    for (int i = 1; i < H; i++) begin
      if (half_q[i] > max_d) max_d = half_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (ld_max) max_q <= max_d;
  end

  // R8: rebase, clamp at the negative limit
  for (genvar s = 0; s < S; s++) begin : g_sub
    logic signed [MW:0] diff;
    always_comb begin
      diff = {acs_q[s][MW-1], acs_q[s]} - {max_q[MW-1], max_q};
      norm_out[s*MW +: MW] = (diff[MW] != diff[MW-1]) ? VMIN : diff[MW-1:0];
    end
  end
endmodule

// File: rtl/ml_metric_step.sv
module ml_metric_step #(
  parameter int SB = 2,
  parameter int MW = 9,
  parameter int CW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    dir,
  input  logic [CW-1:0]           norm_interval,
  input  logic [(1<<SB)*MW-1:0]   metric_in,
  input  logic [2*(1<<SB)*MW-1:0] branch_in,
  output logic                    out_valid,
  output logic [(1<<SB)*MW-1:0]   metric_out
);
  localparam int S = 1 << SB;

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic norm_now, a_vld, a_norm, b_vld, c_vld, d_vld;
  logic [S*MW-1:0] acs_max, norm_out, out_d;
  logic            direct_en, out_en;

  ml_step_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid),
    .norm_interval(norm_interval), .norm_now(norm_now),
    .a_vld(a_vld), .a_norm(a_norm), .b_vld(b_vld), .c_vld(c_vld), .d_vld(d_vld)
  );

  ml_acs_unit #(.SB(SB), .MW(MW)) u_acs (
    .clk(clk), .load_en(in_valid), .dir(dir),
    .metric_in(metric_in), .branch_in(branch_in), .acs_max(acs_max)
  );

  ml_norm_pipe #(.SB(SB), .MW(MW)) u_norm (
    .clk(clk), .ld_acs(a_vld), .ld_half(b_vld), .ld_max(c_vld),
    .acs_in(acs_max), .norm_out(norm_out)
  );

  always_comb begin
    direct_en = a_vld & ~a_norm;
    out_en    = direct_en | d_vld;
    out_d     = direct_en ? acs_max : norm_out;
  end

  always_ff @(posedge clk) begin
    if (out_en) metric_out <= out_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= out_en;
  end
endmodule

// File: rtl/ml_metric_step_chk.sv
module ml_metric_step_chk #(
  parameter int SB = 2,
  parameter int MW = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  norm_now,
  input logic                  out_valid,
  input logic [(1<<SB)*MW-1:0] metric_out
);
  localparam int S = 1 << SB;
  logic all_nonpos, has_zero;

  always_comb begin
    all_nonpos = 1'b1;
    has_zero   = 1'b0;
    for (int s = 0; s < S; s++) begin
      if (!metric_out[s*MW + MW - 1] && metric_out[s*MW +: MW] != '0) all_nonpos = 1'b0;
      if (metric_out[s*MW +: MW] == '0) has_zero = 1'b1;
    end
  end

  assert_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !in_valid);
  assert_norm_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && norm_now) |=> !in_valid ##1 !in_valid ##1 !in_valid);
  assert_plain_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !norm_now) |-> ##2 out_valid);
  assert_norm_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && norm_now) |-> ##5 out_valid);
  assert_norm_rebased_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && norm_now) |-> ##5 (all_nonpos && has_zero));
endmodule

bind ml_metric_step ml_metric_step_chk #(.SB(SB), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .norm_now(norm_now),
  .out_valid(out_valid), .metric_out(metric_out)
);

// File: tb/ml_metric_step_tb_top.sv
module ml_metric_step_tb_top;
  localparam int SB = 2;
  localparam int MW = 9;
  localparam int CW = 4;
  localparam int S  = 1 << SB;
  localparam int NB = 2 * S;
  localparam time CLK_PERIOD = 10ns;

  typedef int vec_t[S];
  typedef int br_t[NB];
  typedef struct {
    int    cyc;
    vec_t  v;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic dir = 1'b0;
  logic [CW-1:0] norm_interval = '0;
  logic [S*MW-1:0] metric_in = '0;
  logic [NB*MW-1:0] branch_in = '0;
  logic out_valid;
  logic [S*MW-1:0] metric_out;

  int checks = 0, failures = 0, cyc = 0, mcnt = 0;
  bit mon_en = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ml_metric_step #(.SB(SB), .MW(MW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir(dir),
    .norm_interval(norm_interval), .metric_in(metric_in), .branch_in(branch_in),
    .out_valid(out_valid), .metric_out(metric_out)
  );

  function automatic int sat(int v);
    if (v > 255) return 255;
    if (v < -256) return -256;
    return v;
  endfunction

  function automatic vec_t model(bit d, vec_t m, br_t g, bit nrm);
    vec_t r;
    int mx;
    for (int s = 0; s < S; s++) begin
      int c0, c1;
      if (d) begin
        c0 = sat(m[(2*s) % S] + g[2*s]);
        c1 = sat(m[(2*s+1) % S] + g[2*s+1]);
      end else begin
        c0 = sat(m[s >> 1] + g[2*(s >> 1) + (s & 1)]);
        c1 = sat(m[(s >> 1) | (1 << (SB-1))] + g[2*((s >> 1) | (1 << (SB-1))) + (s & 1)]);
      end
      r[s] = (c1 > c0) ? c1 : c0;
    end
    if (nrm) begin
      mx = r[0];
      for (int s = 1; s < S; s++) if (r[s] > mx) mx = r[s];
      for (int s = 0; s < S; s++) r[s] = sat(r[s] - mx);
    end
    return r;
  endfunction

  task automatic do_step(input bit d, input int k, input vec_t m, input br_t g,
                         input string tag, output vec_t r);
    bit nrm;
    exp_t e;
    nrm  = (k <= 1) || (mcnt == k - 1);
    mcnt = nrm ? 0 : mcnt + 1;
    r = model(d, m, g, nrm);
    e.cyc = cyc + (nrm ? 5 : 2);
    e.v   = r;
    e.tag = nrm ? {tag, " R7 R8"} : {tag, " R6"};
    q.push_back(e);
    dir = d;
    norm_interval = CW'(k);
    for (int s = 0; s < S; s++) metric_in[s*MW +: MW] = m[s][MW-1:0];
    for (int i = 0; i < NB; i++) branch_in[i*MW +: MW] = g[i][MW-1:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat ((nrm ? 4 : 2) - 1) @(negedge clk);
  endtask

  function automatic vec_t rnd_vec();
    vec_t v;
    for (int s = 0; s < S; s++) v[s] = int'($urandom_range(0, 511)) - 256;
    return v;
  endfunction

  function automatic br_t rnd_br();
    br_t g;
    for (int i = 0; i < NB; i++) g[i] = int'($urandom_range(0, 511)) - 256;
    return g;
  endfunction

  // per-cycle comparison against the reference queue
  always @(negedge clk) begin
    if (mon_en) begin
      bit ev;
      ev = (q.size() > 0) && (q[0].cyc == cyc);
      if (ev || out_valid) begin
        checks++;
        if (out_valid !== ev) begin
          failures++;
          $display("FAIL R6 R7 out_valid at cycle %0d: actual %0b expected %0b", cyc, out_valid, ev);
        end
      end
      if (ev) begin
        exp_t e;
        e = q.pop_front();
        for (int s = 0; s < S; s++) begin
          int act;
          act = int'($signed(metric_out[s*MW +: MW]));
          checks++;
          if (act != e.v[s]) begin
            failures++;
            $display("FAIL %s state %0d: actual %0d expected %0d", e.tag, s, act, e.v[s]);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t m, r;
    br_t g;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 out_valid in reset: actual %0b expected 0", out_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 out_valid after reset: actual %0b expected 0", out_valid);
    end
    mon_en = 1'b1;

    // interval 15: no rebase yet (R1 count starts at zero)
    for (int i = 0; i < 3; i++) do_step(1'b0, 15, rnd_vec(), rnd_br(), "R2 fwd", r);
    for (int i = 0; i < 3; i++) do_step(1'b1, 15, rnd_vec(), rnd_br(), "R3 bwd", r);
    for (int s = 0; s < S; s++) m[s] = 255;
    for (int i = 0; i < NB; i++) g[i] = 200;
    do_step(1'b0, 15, m, g, "R4 high sat", r);
    for (int s = 0; s < S; s++) m[s] = -256;
    for (int i = 0; i < NB; i++) g[i] = -10;
    do_step(1'b1, 15, m, g, "R4 low sat", r);
    for (int s = 0; s < S; s++) m[s] = 8;
    for (int i = 0; i < NB; i++) g[i] = 4;
    do_step(1'b0, 15, m, g, "R5 tie", r);

    // every-step rebase
    for (int i = 0; i < 3; i++) do_step(i[0], 0, rnd_vec(), rnd_br(), "R8 R9 every", r);
    m[0] = 255; m[1] = 255; m[2] = -256; m[3] = -256;
    for (int i = 0; i < NB; i++) g[i] = 0;
    do_step(1'b1, 0, m, g, "R8 diff clamp", r);
    do_step(1'b0, 1, rnd_vec(), rnd_br(), "R9 interval one", r);

    // interval 4: chained recursion, one rebase every fourth step
    m = rnd_vec();
    for (int i = 0; i < 12; i++) begin
      do_step(1'b0, 4, m, rnd_br(), "R9 R10 chain", r);
      m = r;
    end

    repeat (10) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R6 R7 pending outputs: actual %0d expected 0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule